// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two bidirectional 8-bit buses, called A and B. Each side has its own holding register. Each register is loaded on the rising edge of its own capture clock, from the bus it belongs to. A direction input chooses which bus is driven, and an active-low enable allows driving at all.

The driven bus shows one of two things, picked by a per-direction select line. It can show live data, taken combinationally from the other bus. Or it can show the register contents captured earlier from the other bus.

With the enable held high, the block is in isolation mode and neither bus is driven. Both registers can still capture in this mode, so data can be parked while the buses belong to other agents. Tri-state pins are modelled as a separate input vector, output vector and output-enable vector for each bus.

Top module: `xcvr_top`

## Requirements
- R1: With `oeN` low, `dirAtoB` high drives bus B (`bOe` all ones, `aOe` all zeros), and `dirAtoB` low drives bus A (`aOe` all ones, `bOe` all zeros).
- R2: With `oeN` high, `aOe` and `bOe` are both all zeros (isolation mode).
- R3: A rising edge on `clkAb` stores the value of `aIn` in the A-side register. A rising edge on `clkBa` stores the value of `bIn` in the B-side register.
- R4: The two registers load independently. An edge on one capture clock leaves the other register unchanged, and edges on both clocks in the same cycle load both registers.
- R5: When B is driven, `bOut` equals the A-side register if `selAb` is 1, and equals `aIn` (combinationally) if `selAb` is 0. When A is driven, `aOut` equals the B-side register if `selBa` is 1, and equals `bIn` if `selBa` is 0.
- R6: An asynchronous active-low `rstN` clears both registers and forces `aOe`, `bOe`, `aOut` and `bOut` to zero while it is low.
- R7: In isolation mode, capture edges still load the registers, and the loaded values appear once a bus is later driven in stored mode.
- R8: The driven bus's own input has no effect on its output. An output vector that is not driven reads zero.
- R9: Each output-enable vector is either all ones or all zeros, and `aOe` and `bOe` are never nonzero at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rstN | input | 1 | Asynchronous reset, active low |
| dirAtoB | input | 1 | 1: drive B from the A side; 0: drive A from the B side |
| oeN | input | 1 | Output enable, active low |
| clkAb | input | 1 | Capture clock of the A-side register |
| selAb | input | 1 | B output source: 1 stored, 0 live |
| clkBa | input | 1 | Capture clock of the B-side register |
| selBa | input | 1 | A output source: 1 stored, 0 live |
| aIn | input | 8 | Value read from bus A |
| aOut | output | 8 | Value driven onto bus A |
| aOe | output | 8 | Per-bit drive enable for bus A |
| bIn | input | 8 | Value read from bus B |
| bOut | output | 8 | Value driven onto bus B |
| bOe | output | 8 | Per-bit drive enable for bus B |

## Verification
Each register's state is visible only through stored mode. A register that missed a capture, or was loaded from the wrong clock, shows up the first time its direction is driven with the select set to stored. The bench therefore reads each register back in stored mode straight after every capture and after every isolation phase. A wrong decode of the direction or enable inputs appears on the enable vectors at once, with no clock involved. So each control combination is compared on the half cycle after it is applied.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Strobes passed from the control decode to the datapath
  typedef struct packed {
    logic driveA;
    logic driveB;
    logic useStoredAb;
    logic useStoredBa;
  } xcvrStrobe_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic        rstN,
  input  logic        dirAtoB,
  input  logic        oeN,
  input  logic        selAb,
  input  logic        selBa,
  output xcvrStrobe_t strobe
);
  logic enabled;

  // Driving is allowed only out of reset and with the enable low
  assign enabled = rstN & ~oeN;

  always_comb begin
    strobe             = '0;
    strobe.driveB      = enabled & dirAtoB;
    strobe.driveA      = enabled & ~dirAtoB;
    strobe.useStoredAb = selAb;
    strobe.useStoredBa = selBa;
  end
endmodule

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int W = 8
) (
  input  logic         rstN,
  input  logic         capClk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge capClk or negedge rstN) begin
    if (!rstN) q <= '0;
    else       q <= d;
  end
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic        rstN,
  input  logic        clkAb,
  input  logic        clkBa,
  input  xcvrStrobe_t strobe,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  output logic [W-1:0] aOut,
  output logic [W-1:0] bOut,
  output logic [W-1:0] aOe,
  output logic [W-1:0] bOe,
  output logic [W-1:0] storedAb,
  output logic [W-1:0] storedBa
);
  localparam int NSIDE = 2;

  logic [W-1:0] capIn  [NSIDE];
  logic [W-1:0] capOut [NSIDE];
  logic         capClk [NSIDE];

  // Side 0 holds A data for the B bus, side 1 holds B data for the A bus
  assign capIn[0]  = aIn;
  assign capIn[1]  = bIn;
  assign capClk[0] = clkAb;
  assign capClk[1] = clkBa;

  for (genvar s = 0; s < NSIDE; s++) begin : gSide
    xcvr_capture_reg #(.W(W)) uReg (
      .rstN  (rstN),
      .capClk(capClk[s]),
      .d     (capIn[s]),
      .q     (capOut[s])
    );
  end

  assign storedAb = capOut[0];
  assign storedBa = capOut[1];

  logic [W-1:0] srcB;
  logic [W-1:0] srcA;

  // Live data comes only from the opposite bus input
  assign srcB = strobe.useStoredAb ? storedAb : aIn;
  assign srcA = strobe.useStoredBa ? storedBa : bIn;

  for (genvar i = 0; i < W; i++) begin : gBit
    assign bOe[i]  = strobe.driveB;
    assign aOe[i]  = strobe.driveA;
    assign bOut[i] = strobe.driveB & srcB[i];
    assign aOut[i] = strobe.driveA & srcA[i];
  end
endmodule

// File: rtl/xcvr_top.sv
module xcvr_top
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         rstN,
  input  logic         dirAtoB,
  input  logic         oeN,
  input  logic         clkAb,
  input  logic         selAb,
  input  logic         clkBa,
  input  logic         selBa,
  input  logic [W-1:0] aIn,
  output logic [W-1:0] aOut,
  output logic [W-1:0] aOe,
  input  logic [W-1:0] bIn,
  output logic [W-1:0] bOut,
  output logic [W-1:0] bOe
);
  xcvrStrobe_t  strobe;
  logic [W-1:0] storedAb;
  logic [W-1:0] storedBa;

  xcvr_ctrl uCtrl (
    .rstN   (rstN),
    .dirAtoB(dirAtoB),
    .oeN    (oeN),
    .selAb  (selAb),
    .selBa  (selBa),
    .strobe (strobe)
  );

  xcvr_datapath #(.W(W)) uPath (
    .rstN    (rstN),
    .clkAb   (clkAb),
    .clkBa   (clkBa),
    .strobe  (strobe),
    .aIn     (aIn),
    .bIn     (bIn),
    .aOut    (aOut),
    .bOut    (bOut),
    .aOe     (aOe),
    .bOe     (bOe),
    .storedAb(storedAb),
    .storedBa(storedBa)
  );
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int W = 8
) (
  input logic         rstN,
  input logic         dirAtoB,
  input logic         oeN,
  input logic         clkAb,
  input logic         selAb,
  input logic         clkBa,
  input logic         selBa,
  input logic [W-1:0] aIn,
  input logic [W-1:0] bIn,
  input logic [W-1:0] aOut,
  input logic [W-1:0] bOut,
  input logic [W-1:0] aOe,
  input logic [W-1:0] bOe,
  input logic [W-1:0] storedAb,
  input logic [W-1:0] storedBa
);
  // R9
  no_dual_drive_chk: assert property (@(posedge clkAb) disable iff (!rstN)
    !((|aOe) && (|bOe)));

  // R9
  oe_uniform_chk: assert property (@(posedge clkBa) disable iff (!rstN)
    (aOe == '0 || aOe == '1) && (bOe == '0 || bOe == '1));

  // R2
  isolation_quiet_chk: assert property (@(posedge clkAb) disable iff (!rstN)
    oeN |-> (aOe == '0 && bOe == '0));

  // R3
  ab_capture_chk: assert property (@(posedge clkAb) disable iff (!rstN)
    1'b1 |=> storedAb == $past(aIn));

  // R3
  ba_capture_chk: assert property (@(posedge clkBa) disable iff (!rstN)
    1'b1 |=> storedBa == $past(bIn));

  // R5
  b_stored_view_chk: assert property (@(posedge clkAb) disable iff (!rstN)
    (!oeN && dirAtoB && selAb) |-> bOut == storedAb);

  // R1
  a_drive_dir_chk: assert property (@(posedge clkBa) disable iff (!rstN)
    (!oeN && !dirAtoB) |-> (aOe == '1 && bOe == '0));
endmodule

bind xcvr_top xcvr_chk #(.W(W)) uChk (
  .rstN(rstN), .dirAtoB(dirAtoB), .oeN(oeN), .clkAb(clkAb), .selAb(selAb),
  .clkBa(clkBa), .selBa(selBa), .aIn(aIn), .bIn(bIn), .aOut(aOut),
  .bOut(bOut), .aOe(aOe), .bOe(bOe), .storedAb(storedAb), .storedBa(storedBa)
);

// File: tb/tb_xcvr_top.sv
module tb_xcvr_top;
  localparam int W = 8;

  typedef struct {
    logic [W-1:0] aOut;
    logic [W-1:0] aOe;
    logic [W-1:0] bOut;
    logic [W-1:0] bOe;
    string        tag;
  } expItem_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rstN = 1'b0, dirAtoB = 1'b0, oeN = 1'b1;
  logic         clkAb = 1'b0, selAb = 1'b0, clkBa = 1'b0, selBa = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic [W-1:0] aOut, aOe, bOut, bOe;

  xcvr_top #(.W(W)) dut (
    .rstN(rstN), .dirAtoB(dirAtoB), .oeN(oeN), .clkAb(clkAb), .selAb(selAb),
    .clkBa(clkBa), .selBa(selBa), .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe)
  );

  expItem_t     sb[$];
  int           checks = 0;
  int           errors = 0;
  logic [W-1:0] modAb = '0;
  logic [W-1:0] modBa = '0;

  // Driver: apply static inputs, push the expected port values
  task automatic apply(input logic r, input logic d, input logic oe,
                       input logic sAb, input logic sBa,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       input string tag);
    expItem_t e;
    logic drvA, drvB;
    @(posedge clk);
    rstN = r; dirAtoB = d; oeN = oe; selAb = sAb; selBa = sBa;
    aIn = a; bIn = b;
    if (!r) begin modAb = '0; modBa = '0; end
    drvB = r && !oe && d;
    drvA = r && !oe && !d;
    e.bOe  = drvB ? '1 : '0;
    e.aOe  = drvA ? '1 : '0;
    e.bOut = drvB ? (sAb ? modAb : a) : '0;
    e.aOut = drvA ? (sBa ? modBa : b) : '0;
    e.tag  = tag;
    sb.push_back(e);
  endtask

  // Capture pulses on one or both register clocks
  task automatic pulse(input logic doAb, input logic doBa);
    @(posedge clk);
    if (doAb) begin clkAb = 1'b1; if (rstN) modAb = aIn; end
    if (doBa) begin clkBa = 1'b1; if (rstN) modBa = bIn; end
    @(posedge clk);
    clkAb = 1'b0; clkBa = 1'b0;
  endtask

  // Monitor: compare design outputs against the queue away from the edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        expItem_t e;
        e = sb.pop_front();
        checks++;
        if (aOut !== e.aOut || aOe !== e.aOe || bOut !== e.bOut || bOe !== e.bOe) begin
          errors++;
          $display("FAIL %s: aOut=%h aOe=%h bOut=%h bOe=%h expected aOut=%h aOe=%h bOut=%h bOe=%h",
                   e.tag, aOut, aOe, bOut, bOe, e.aOut, e.aOe, e.bOut, e.bOe);
        end
      end
    end
  end

  logic done = 1'b0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R6: reset forces everything low, even with drive requested
    apply(0, 1, 0, 0, 0, 8'h5A, 8'hA5, "R6 reset state");
    pulse(1, 1);
    apply(0, 0, 0, 1, 1, 8'h5A, 8'hA5, "R6 reset holds registers");
    // R1/R5: drive B live from A
    apply(1, 1, 0, 0, 0, 8'h3C, 8'h00, "R1 drive B live");
    apply(1, 1, 0, 0, 0, 8'hC3, 8'h00, "R5 live follows aIn");
    // R8: driven bus own input ignored
    apply(1, 1, 0, 0, 0, 8'hC3, 8'h77, "R8 bIn ignored while B driven");
    // R3/R5: capture A then show stored
    apply(1, 1, 0, 0, 0, 8'hA5, 8'h77, "R3 setup");
    pulse(1, 0);
    apply(1, 1, 0, 1, 0, 8'h11, 8'h77, "R3 R5 stored A view");
    // R1: drive A live from B
    apply(1, 0, 0, 0, 0, 8'h11, 8'h66, "R1 drive A live");
    apply(1, 0, 0, 0, 0, 8'h22, 8'h66, "R8 aIn ignored while A driven");
    // R4: both registers in one cycle
    apply(1, 1, 0, 0, 0, 8'h12, 8'h34, "R4 setup both");
    pulse(1, 1);
    apply(1, 1, 0, 1, 0, 8'h00, 8'h00, "R4 both loaded A side");
    apply(1, 0, 0, 0, 1, 8'h00, 8'h00, "R4 both loaded B side");
    // R4: only B loads, A register stays
    apply(1, 0, 0, 0, 1, 8'h99, 8'h56, "R4 setup B only");
    pulse(0, 1);
    apply(1, 0, 0, 0, 1, 8'h99, 8'h00, "R4 B register updated");
    apply(1, 1, 0, 1, 0, 8'h99, 8'h00, "R4 A register untouched");
    // R2/R7: isolation capture
    apply(1, 1, 1, 1, 1, 8'hE7, 8'h7E, "R2 isolation dir high");
    apply(1, 0, 1, 0, 0, 8'hE7, 8'h7E, "R2 isolation dir low");
    pulse(1, 1);
    apply(1, 1, 0, 1, 0, 8'h00, 8'h00, "R7 isolation-captured A");
    apply(1, 0, 0, 0, 1, 8'h00, 8'h00, "R7 isolation-captured B");
    // R9: enable exclusivity on a direction flip
    apply(1, 1, 0, 0, 0, 8'h0F, 8'hF0, "R9 enables exclusive");
    // R6: asynchronous reset mid-run clears registers
    apply(0, 1, 0, 1, 1, 8'h0F, 8'hF0, "R6 reset mid-run");
    apply(1, 1, 0, 1, 1, 8'h0F, 8'hF0, "R6 A register cleared");
    apply(1, 0, 0, 1, 1, 8'h0F, 8'hF0, "R6 B register cleared");
    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule